// File: doc/BRIEF.md
# Code-Selected Reference Frequency Divider

This block divides a reference clock by one of eight fixed ratios and produces a pulse train for the reference input of a phase comparator. A 3-bit ratio code picks the ratio. A small lookup turns the code into a terminal count. A down-counter reloads that count each time it reaches zero, and it emits a single-cycle pulse at each wrap. Because the ratio set contains a ratio that is not a power of two, the block cannot simply tap a binary prescaler.

A parameter selects one of two ratio sets. The wide set, used by default, maps codes 0 to 7 onto 8, 128, 256, 512, 1024, 2048, 2410 and 8192. The narrow set maps codes 0 to 7 onto 8, 64, 128, 256, 512, 1024, 1160 and 2048. Code inputs left unconnected on the board read as ones, so the default code 3'b111 selects the largest entry of the chosen set. The counter samples the code only when it reloads. A code change therefore begins at the next wrap and does not cut short the period that is running.

Top module: `refdiv_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge drives `ref_pulse` and `pulse_valid` to 0.
- R2: With the wide set and a steady code, `ref_pulse` repeats every N clocks. N is 8, 128, 256, 512, 1024, 2048, 2410 and 8192 for codes 0 to 7 respectively.
- R3: `ref_pulse` is high for exactly one clock per period.
- R4: The code is sampled only at the edge on which `ref_pulse` rises. A code changed partway through a period leaves that period at its old length, and the following period takes the new ratio.
- R5: Reset loads the counter from the code present during reset, so the first `ref_pulse` is high exactly N clock edges after the last edge at which `rst` was high.
- R6: `pulse_valid` stays 0 from reset until the first `ref_pulse`, rises in the same cycle as that pulse, and stays 1 until the next reset.
- R7: With the narrow set (parameter `RATIO_SET` = `SET_NARROW`), the period for codes 0 to 7 is 8, 64, 128, 256, 512, 1024, 1160 and 2048 clocks respectively.
- R8: Between wraps the internal count falls by exactly one per clock, and each wrap reloads the terminal count of the code sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_code | input | 3 | Ratio select code, 3'b111 when left undriven on the board |
| ref_pulse | output | 1 | One-cycle pulse at each period boundary of the divided reference |
| pulse_valid | output | 1 | High once the first full period since reset has completed |

## Verification
The assertions take it for granted that `ratio_code` settles before each rising edge and that every ratio is at least 2. A single-cycle pulse can only be followed by a low cycle when the ratio is 2 or more, and the smallest ratio in both sets is 8. The stimulus changes the code and reset only on falling edges. It also moves the code at several points within a period, including the cycles just after a wrap, so the hold-until-reload rule is exercised.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  localparam int CODE_W    = 3;
  localparam int NUM_CODES = 1 << CODE_W;

  typedef enum logic {
    SET_WIDE   = 1'b0,
    SET_NARROW = 1'b1
  } ratio_set_e;

  // Divide ratio for a code within a given set.
  function automatic int unsigned ratio_for(ratio_set_e s, logic [CODE_W-1:0] code);
    int unsigned r;
    if (s == SET_WIDE) begin
      case (code)
        3'd0:    r = 8;
        3'd6:    r = 2410;
        3'd7:    r = 8192;
        default: r = 32'd1 << (int'(code) + 6);
      endcase
    end else begin
      case (code)
        3'd0:    r = 8;
        3'd6:    r = 1160;
        3'd7:    r = 2048;
        default: r = 32'd1 << (int'(code) + 5);
      endcase
    end
    return r;
  endfunction

  // Value loaded into the down-counter: ratio minus one.
  function automatic int unsigned terminal_for(ratio_set_e s, logic [CODE_W-1:0] code);
    return ratio_for(s, code) - 1;
  endfunction

  // Largest ratio present in a set, used to size the counter.
  function automatic int unsigned max_ratio(ratio_set_e s);
    int unsigned m;
    m = 0;
    for (int i = 0; i < NUM_CODES; i++) begin
      if (ratio_for(s, i[CODE_W-1:0]) > m) m = ratio_for(s, i[CODE_W-1:0]);
    end
    return m;
  endfunction

endpackage

// File: rtl/refdiv_lut.sv
module refdiv_lut
  import refdiv_pkg::*;
#(
  parameter ratio_set_e RATIO_SET = SET_WIDE,
  parameter int         CNT_W     = 13
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  term_count
);

  logic [CNT_W-1:0] table_q [NUM_CODES];

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_entry
    assign table_q[g] = CNT_W'(terminal_for(RATIO_SET, g[CODE_W-1:0]));
  end

  assign term_count = table_q[code];

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             term_hit
);

  assign term_hit = (count == '0);

  always_ff @(posedge clk) begin
    if (rst || term_hit) count <= load_val;
    else                 count <= count - 1'b1;
  end

endmodule

// File: rtl/refdiv_pulse.sv
module refdiv_pulse (
  input  logic clk,
  input  logic rst,
  input  logic term_hit,
  output logic ref_pulse,
  output logic pulse_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_pulse   <= 1'b0;
      pulse_valid <= 1'b0;
    end else begin
      ref_pulse   <= term_hit;
      pulse_valid <= pulse_valid | term_hit;
    end
  end

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter ratio_set_e RATIO_SET = SET_WIDE,
  parameter int         CNT_W     = $clog2(max_ratio(RATIO_SET))
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  ratio_code,
  output logic        ref_pulse,
  output logic        pulse_valid
);

  logic [CNT_W-1:0] term_count;
  logic [CNT_W-1:0] cnt_q;
  logic             term_hit;

  refdiv_lut #(.RATIO_SET(RATIO_SET), .CNT_W(CNT_W)) u_lut (
    .code       (ratio_code),
    .term_count (term_count)
  );

  refdiv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_val (term_count),
    .count    (cnt_q),
    .term_hit (term_hit)
  );

  refdiv_pulse u_pls (
    .clk         (clk),
    .rst         (rst),
    .term_hit    (term_hit),
    .ref_pulse   (ref_pulse),
    .pulse_valid (pulse_valid)
  );

endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_pulse,
  input logic             pulse_valid,
  input logic             term_hit,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] load_val
);

  // R1: a reset edge clears both outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!ref_pulse && !pulse_valid));

  // R2: every wrap of the counter produces a pulse
  p_wrap_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    term_hit |=> ref_pulse);

  // R3: pulse lasts one clock
  p_one_wide_r3: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |=> !ref_pulse);

  // R6: valid accompanies every pulse and never drops without reset
  p_pulse_valid_r6: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |-> pulse_valid);
  p_valid_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    pulse_valid |=> pulse_valid);

  // R8, R4: count steps down between wraps; reload takes the sampled code
  p_step_r8: assert property (@(posedge clk) disable iff (rst)
    !term_hit |=> count == $past(count) - CNT_W'(1));
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    term_hit |=> count == $past(load_val));

endmodule

bind refdiv_top refdiv_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ref_pulse   (ref_pulse),
  .pulse_valid (pulse_valid),
  .term_hit    (term_hit),
  .count       (cnt_q),
  .load_val    (term_count)
);

// File: tb/refdiv_top_tb.sv
module refdiv_top_tb;
  import refdiv_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] code = 3'd7;
  logic       pw, vw, pn, vn;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  refdiv_top #(.RATIO_SET(SET_WIDE)) u_dut (
    .clk(clk), .rst(rst), .ratio_code(code), .ref_pulse(pw), .pulse_valid(vw));

  refdiv_top #(.RATIO_SET(SET_NARROW)) u_dut_alt (
    .clk(clk), .rst(rst), .ratio_code(code), .ref_pulse(pn), .pulse_valid(vn));

  // Expected ratios restated as plain lists
  function automatic int exp_ratio(bit narrow, int c);
    int w [8] = '{8, 128, 256, 512, 1024, 2048, 2410, 8192};
    int n [8] = '{8, 64, 128, 256, 512, 1024, 1160, 2048};
    return narrow ? n[c] : w[c];
  endfunction

  // Behavioural model: cycles remaining until the next pulse
  int  left [2];
  bit  m_pulse [2];
  bit  m_valid [2];

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        left[k] = exp_ratio(k == 1, int'(code));
        m_pulse[k] = 0;
        m_valid[k] = 0;
      end else begin
        left[k] = left[k] - 1;
        if (left[k] == 0) begin
          m_pulse[k] = 1;
          m_valid[k] = 1;
          left[k] = exp_ratio(k == 1, int'(code));
        end else begin
          m_pulse[k] = 0;
        end
      end
    end
    cycles++;
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (cycles > 0) begin
      check(cur_req, "wide pulse", int'(pw), int'(m_pulse[0]));
      check("R6", "wide valid", int'(vw), int'(m_valid[0]));
      check("R7", "narrow pulse", int'(pn), int'(m_pulse[1]));
      check("R7", "narrow valid", int'(vn), int'(m_valid[1]));
    end
  end

  task automatic wait_pulse();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (pw) return;
    end
  endtask

  task automatic period(output int p);
    p = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      p++;
      if (pw) return;
    end
  endtask

  initial begin
    int p;
    #0;
    if (cycles >= 190000) ;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "pulse in reset", int'(pw), 0);
    check("R1", "valid in reset", int'(vw), 0);
    // R5: first pulse N edges after reset release, code 7 -> 8192
    cur_req = "R5";
    rst = 1'b0;
    period(p);
    check("R5", "cycles to first pulse", p, 8192);
    check("R6", "valid with first pulse", int'(vw), 1);
    // R2: each code's period
    cur_req = "R2";
    for (int c = 0; c < 8; c++) begin
      code = 3'(c);
      wait_pulse();
      wait_pulse();
      period(p);
      check("R2", $sformatf("period code %0d", c), p, exp_ratio(0, c));
      check("R3", "pulse width", int'(pw), 1);
      @(negedge clk);
      check("R3", "pulse falls", int'(pw), 0);
      p = p + 0;
    end
    // R4: change mid-period, 8 -> 128
    cur_req = "R4";
    code = 3'd0;
    wait_pulse();
    wait_pulse();
    repeat (3) @(negedge clk);
    code = 3'd1;
    period(p);
    check("R4", "period after mid change", p + 3, 8);
    period(p);
    check("R4", "following period", p, 128);
    // R4: change right after a wrap
    wait_pulse();
    code = 3'd6;
    period(p);
    check("R4", "period after change at wrap", p, 128);
    period(p);
    check("R4", "next period code 6", p, 2410);
    // R1/R6: reset mid-operation
    cur_req = "R1";
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "pulse after reset", int'(pw), 0);
    check("R6", "valid after reset", int'(vw), 0);
    code = 3'd2;
    @(negedge clk);
    rst = 1'b0;
    cur_req = "R5";
    period(p);
    check("R5", "first pulse code 2", p, 256);
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=<190000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule